// File: doc/BRIEF.md
# Masked-Address GPIO Port with Pin Interrupts

This block is an eight-line general-purpose I/O port that sits on a simple memory-mapped register bus with valid, write, address and data signals. Each line can be an input or an output. It drives output levels and output enables to the pads and samples the pad inputs through a two-stage synchronizer. The data register is reached through a window of 256 word addresses. In that window the word address bits act as a per-pin mask. Software can therefore set or clear single pins in one write, with no read-modify-write.

Each pin also has an interrupt detector. The detector senses either a level or a latched edge. For edges it can take one chosen edge or both edges. For edges and levels it takes a chosen polarity. The raw status is ANDed with a per-pin enable, and the results are ORed into one interrupt output. Four read-only bytes at the top of the address space return a fixed identification value. Read data is registered and appears on `bus_rdata` in the cycle after the read.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every pin is an input (`pad_oe` = 0), the output register is 0, every interrupt configuration register reads 0 and `irq` is low.
- R2: Byte offsets below 0x400 all address the data register. Address bit n+2 is the mask bit for pin n, so an access at offset 0x000 touches no pin.
- R3: The direction register at offset 0x400 reads back as written. Bit n = 1 makes pin n an output, and `pad_oe` follows the register from the cycle after the write.
- R4: A data write updates `pad_out` only on pins whose mask bit is set. Every other output bit keeps its value.
- R5: A data write leaves the stored output value of any pin that is currently an input unchanged. A later switch to output then drives the old value.
- R6: A data read returns the pin level in each masked position and 0 in each unmasked position. The level is the output register for output pins and the synchronized pad for input pins.
- R7: With the sense bit (offset 0x404) at 0, a pin latches an edge flag into raw status (offset 0x414). The flag is set on either edge when its both-edges bit (offset 0x408) is 1. Otherwise it is set on a rising edge when its polarity bit (offset 0x40C) is 1, and on a falling edge when that bit is 0. Edge detection acts on pad values after two synchronizer flops.
- R8: With the sense bit at 1, raw status follows the synchronized level: it is 1 while the pin equals its polarity bit. A level status is not latched and is not affected by the clear register.
- R9: Writing 1 to bit n of the clear register (offset 0x41C) clears the latched edge flag of pin n.
- R10: Masked status (offset 0x418) equals raw status AND the enable register (offset 0x410), and `irq` is the OR of masked status. Writing 0 to the enable register masks every pin.
- R11: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC read 0x61, 0x10, 0x04 and 0x00, in that order.
- R12: Undefined offsets read 0 and ignore writes. Writes to raw and masked status have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte address bits 11:2) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Output levels to the pads |
| pad_oe | output | 8 | Output enables to the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest state to reach is an edge flag that is still latched after the pin that set it has returned to its earlier level, while a level-sensed pin on the same port is asserted at the same time. Clear, enable and polarity must then be shown to act on one kind of status and not the other. The stimulus walks the pad inputs one bit at a time and waits out the synchronizer latency after each step. It reads raw status after every change, then clears and masks pins in an order that leaves both kinds of status set together.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

    // Word indices (byte offset >> 2) of the control registers
    localparam logic [9:0] W_DIR   = 10'h100;
    localparam logic [9:0] W_SENSE = 10'h101;
    localparam logic [9:0] W_BOTH  = 10'h102;
    localparam logic [9:0] W_POL   = 10'h103;
    localparam logic [9:0] W_EN    = 10'h104;
    localparam logic [9:0] W_RAW   = 10'h105;
    localparam logic [9:0] W_MIS   = 10'h106;
    localparam logic [9:0] W_CLR   = 10'h107;
    localparam logic [9:0] W_ID0   = 10'h3F8;
    localparam int unsigned ID_BYTES = 4;

    localparam logic [31:0] PORT_ID = 32'h0004_1061;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_SENSE,
        SEL_BOTH,
        SEL_POL,
        SEL_EN,
        SEL_RAW,
        SEL_MIS,
        SEL_CLR,
        SEL_ID
    } reg_sel_e;

    function automatic logic [7:0] id_byte(input logic [1:0] idx);
        return PORT_ID[idx*8 +: 8];
    endfunction

endpackage

// File: rtl/gpio_mp_decode.sv
module gpio_mp_decode
    import gpio_mp_pkg::*;
#(
    parameter int unsigned WORD_W = 10
) (
    input  logic [WORD_W-1:0] word,
    output reg_sel_e          sel,
    output logic [1:0]        id_idx
);

    always_comb begin
        sel    = SEL_NONE;
        id_idx = word[1:0];
        if (word[WORD_W-1 -: 2] == 2'b00) begin
            sel = SEL_DATA;
        end else if (word >= WORD_W'(W_ID0) &&
                     word <  WORD_W'(W_ID0 + 10'(ID_BYTES))) begin
            sel = SEL_ID;
        end else begin
            unique case (word)
                WORD_W'(W_DIR):   sel = SEL_DIR;
                WORD_W'(W_SENSE): sel = SEL_SENSE;
                WORD_W'(W_BOTH):  sel = SEL_BOTH;
                WORD_W'(W_POL):   sel = SEL_POL;
                WORD_W'(W_EN):    sel = SEL_EN;
                WORD_W'(W_RAW):   sel = SEL_RAW;
                WORD_W'(W_MIS):   sel = SEL_MIS;
                WORD_W'(W_CLR):   sel = SEL_CLR;
                default:          sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/gpio_mp_sync.sv
module gpio_mp_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_mp_irq.sv
module gpio_mp_irq #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] sense,
    input  logic [N-1:0] both,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] en,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw,
    output logic [N-1:0] mis,
    output logic         irq
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] flag;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic [N-1:0] rise, fall, event_hit, lvl_hit;

    always_comb begin
        rise      = pin & ~st_q.prev;
        fall      = ~pin & st_q.prev;
        event_hit = (both & (rise | fall))
                  | (~both & pol & rise)
                  | (~both & ~pol & fall);
        lvl_hit   = ~(pin ^ pol);

        st_d      = st_q;
        st_d.prev = pin;
        // a new event in the same cycle wins over a clear
        st_d.flag = (st_q.flag & ~clr) | (event_hit & ~sense);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw = (sense & lvl_hit) | (~sense & st_q.flag);
    assign mis = raw & en;
    assign irq = |mis;

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mp_pkg::*;
#(
    parameter int unsigned N_PINS      = 8,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:2] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic              irq
);

    localparam int unsigned WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic [N_PINS-1:0] dir;
        logic [N_PINS-1:0] outv;
        logic [N_PINS-1:0] sense;
        logic [N_PINS-1:0] both;
        logic [N_PINS-1:0] pol;
        logic [N_PINS-1:0] en;
        logic [N_PINS-1:0] rdata;
    } port_st_t;

    port_st_t st_d, st_q;

    reg_sel_e          sel;
    logic [1:0]        id_idx;
    logic [N_PINS-1:0] pin_sync, raw, mis, clr, amask, wmask, level, rd_val;

    gpio_mp_decode #(.WORD_W(WORD_W)) u_dec (
        .word   (bus_addr),
        .sel    (sel),
        .id_idx (id_idx)
    );

    gpio_mp_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_sync)
    );

    gpio_mp_irq #(.N(N_PINS)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_sync),
        .sense (st_q.sense),
        .both  (st_q.both),
        .pol   (st_q.pol),
        .en    (st_q.en),
        .clr   (clr),
        .raw   (raw),
        .mis   (mis),
        .irq   (irq)
    );

    assign amask = bus_addr[N_PINS+1:2];
    assign wmask = amask & st_q.dir;
    assign level = (st_q.dir & st_q.outv) | (~st_q.dir & pin_sync);

    always_comb begin
        unique case (sel)
            SEL_DATA:  rd_val = level & amask;
            SEL_DIR:   rd_val = st_q.dir;
            SEL_SENSE: rd_val = st_q.sense;
            SEL_BOTH:  rd_val = st_q.both;
            SEL_POL:   rd_val = st_q.pol;
            SEL_EN:    rd_val = st_q.en;
            SEL_RAW:   rd_val = raw;
            SEL_MIS:   rd_val = mis;
            SEL_ID:    rd_val = N_PINS'(id_byte(id_idx));
            default:   rd_val = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (bus_valid && bus_write) begin
            unique case (sel)
                SEL_DATA:  st_d.outv  = (st_q.outv & ~wmask) | (bus_wdata & wmask);
                SEL_DIR:   st_d.dir   = bus_wdata;
                SEL_SENSE: st_d.sense = bus_wdata;
                SEL_BOTH:  st_d.both  = bus_wdata;
                SEL_POL:   st_d.pol   = bus_wdata;
                SEL_EN:    st_d.en    = bus_wdata;
                SEL_CLR:   clr        = bus_wdata;
                default:   ;
            endcase
        end
        if (bus_valid && !bus_write) begin
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pad_out   = st_q.outv;
    assign pad_oe    = st_q.dir;
    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
    parameter int unsigned N_PINS = 8,
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:2] bus_addr,
    input logic [N_PINS-1:0] bus_wdata,
    input logic [N_PINS-1:0] bus_rdata,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_oe,
    input logic              irq
);

    logic              in_data, is_known, is_id0, wr, rd;
    logic [N_PINS-1:0] amask;

    assign wr      = bus_valid && bus_write;
    assign rd      = bus_valid && !bus_write;
    assign in_data = (bus_addr[ADDR_W-1 -: 2] == 2'b00);
    assign amask   = bus_addr[N_PINS+1:2];
    assign is_id0  = (bus_addr == (ADDR_W-2)'(10'h3F8));
    assign is_known = in_data
        || (bus_addr >= (ADDR_W-2)'(10'h100) && bus_addr <= (ADDR_W-2)'(10'h107))
        || (bus_addr >= (ADDR_W-2)'(10'h3F8) && bus_addr <= (ADDR_W-2)'(10'h3FB));

    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == (ADDR_W-2)'(10'h100) |=> pad_oe == $past(bus_wdata));

    p_masked_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr && in_data |=> ((pad_out ^ $past(pad_out)) & ~$past(amask)) == '0);

    p_input_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr && in_data |=> ((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0);

    p_read_unmasked_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd && in_data |=> (bus_rdata & ~$past(amask)) == '0);

    p_enable_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == (ADDR_W-2)'(10'h104) && bus_wdata == '0 |=> !irq);

    p_id_low_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd && is_id0 |=> bus_rdata == N_PINS'(8'h61));

    p_undefined_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !is_known |=> bus_rdata == '0);

endmodule

bind gpio_mask_port gpio_mask_port_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq)
);

// File: tb/gpio_mask_port_bench.sv
module gpio_mask_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0;
    logic       bus_write = 1'b0;
    logic [11:2] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic rd_seen = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    gpio_mask_port u_gpio_mask_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: a read registered at a posedge is compared at the next negedge
    always @(posedge clk) rd_seen <= rst_n && bus_valid && !bus_write;

    initial begin
        forever begin
            @(negedge clk);
            if (rd_seen) begin
                if (sb_q.size() == 0) begin
                    check("scoreboard underflow", 8'h00, 8'h01);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a[11:2]; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a[11:2];
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd(12'h400, 8'h00, "R1 dir reset");
        rd(12'h410, 8'h00, "R1 enable reset");
        rd(12'h40C, 8'h00, "R1 polarity reset");

        // R11 identification bytes
        rd(12'hFE0, 8'h61, "R11 id0");
        rd(12'hFE4, 8'h10, "R11 id1");
        rd(12'hFE8, 8'h04, "R11 id2");
        rd(12'hFEC, 8'h00, "R11 id3");

        // R12 undefined and read-only offsets
        rd(12'h420, 8'h00, "R12 undefined read");
        wr(12'h800, 8'hFF);
        rd(12'h800, 8'h00, "R12 undefined write ignored");
        wr(12'h414, 8'hFF);
        rd(12'h414, 8'h00, "R12 raw status not writable");

        // R3 direction
        wr(12'h400, 8'h0F);
        check("R3 pad_oe", pad_oe, 8'h0F);
        rd(12'h400, 8'h0F, "R3 dir readback");

        // R5 writes to input pins do not store
        wr(12'h3FC, 8'hFF);
        check("R5 input pins untouched", pad_out, 8'h0F);
        wr(12'h400, 8'hFF);
        check("R5 value kept after dir switch", pad_out, 8'h0F);

        // R4 / R2 masked writes
        wr(12'h0C0, 8'hFF);
        check("R4 mask 0x30 set", pad_out, 8'h3F);
        wr(12'h004, 8'h00);
        check("R4 mask 0x01 clear", pad_out, 8'h3E);
        wr(12'h000, 8'h00);
        check("R2 empty mask", pad_out, 8'h3E);

        // R6 masked reads
        wr(12'h400, 8'h0F);
        pad_in = 8'hA5;
        idle(3);
        rd(12'h3FC, 8'hAE, "R6 full mask read");
        rd(12'h030, 8'h0C, "R6 mask 0x0C read");
        rd(12'h200, 8'h80, "R6 mask 0x80 read");
        rd(12'h000, 8'h00, "R2 empty mask read");

        // R7 default falling-edge latch from 0xA5 -> 0x00
        pad_in = 8'h00;
        idle(4);
        rd(12'h414, 8'hA5, "R7 default falling edges");
        wr(12'h41C, 8'hFF);
        rd(12'h414, 8'h00, "R9 clear all");

        // configure: pin0 rising, pin1 falling, pin2 both, pin3 level-high
        wr(12'h40C, 8'h09);
        wr(12'h408, 8'h04);
        wr(12'h404, 8'h08);
        wr(12'h410, 8'h0F);
        rd(12'h410, 8'h0F, "R10 enable readback");
        rd(12'h414, 8'h00, "R8 level idle");
        check("R10 irq idle", {7'd0, irq}, 8'h00);

        pad_in = 8'h01; idle(4);
        rd(12'h414, 8'h01, "R7 rising edge");
        check("R10 irq on flag", {7'd0, irq}, 8'h01);

        pad_in = 8'h03; idle(4);
        rd(12'h414, 8'h01, "R7 rising ignored on falling pin");
        pad_in = 8'h01; idle(4);
        rd(12'h414, 8'h03, "R7 falling edge");
        pad_in = 8'h05; idle(4);
        rd(12'h414, 8'h07, "R7 both edges rise");

        wr(12'h41C, 8'h07);
        rd(12'h414, 8'h00, "R9 clear flags");
        check("R9 irq after clear", {7'd0, irq}, 8'h00);

        pad_in = 8'h01; idle(4);
        rd(12'h414, 8'h04, "R7 both edges fall");
        pad_in = 8'h00; idle(4);
        rd(12'h414, 8'h04, "R7 falling ignored on rising pin");

        pad_in = 8'h08; idle(4);
        rd(12'h414, 8'h0C, "R8 level high");
        wr(12'h41C, 8'h08);
        rd(12'h414, 8'h0C, "R8 clear has no effect on level");
        rd(12'h418, 8'h0C, "R10 masked status");

        wr(12'h410, 8'h00);
        check("R10 enable zero irq", {7'd0, irq}, 8'h00);
        rd(12'h418, 8'h00, "R10 masked status zero");
        rd(12'h414, 8'h0C, "R10 raw unaffected by enable");

        wr(12'h410, 8'h08);
        rd(12'h418, 8'h08, "R10 partial enable");
        check("R10 irq partial", {7'd0, irq}, 8'h01);

        pad_in = 8'h00; idle(3);
        rd(12'h414, 8'h04, "R8 level follows pin low");
        check("R10 irq after level drop", {7'd0, irq}, 8'h00);

        idle(3);
        if (sb_q.size() != 0) check("scoreboard drained", 8'(sb_q.size()), 8'h00);
        finish_run();
    end

endmodule